// File: doc/BRIEF.md
# Interrupt CPU Interface with Acknowledge and Completion

This block sits between an interrupt distributor and one processor core. Every cycle it takes the per-line enable, pending, group and priority state from the distributor. It keeps its own record of which lines the core is currently servicing. From the lines that qualify it picks one winner and signals it on either the normal or the fast interrupt output.

The core reaches the block through a 32-bit register port with four registers: a control word, a priority mask, an acknowledge register that is read and an end-of-interrupt register that is written. Reading the acknowledge register returns the winning line and marks it as being serviced. In the same cycle the block pulses a clear-pending strobe back to the distributor. Writing the returned word to the end-of-interrupt register releases the line again.

Top module: `intc_cpu_iface`

## Requirements
- R1: After reset, `irq` and `fiq` are low, the control and mask registers read 0, and an acknowledge read returns 1023.
- R2: Register byte offsets are control 0x000, priority mask 0x004, acknowledge 0x00C and end-of-interrupt 0x010. In the control word, bit 0 enables group 0, bit 1 enables group 1 and bit 3 steers group 0 to `fiq`; all other control bits read 0. The mask holds write-data bits [7:0].
- R3: A line qualifies only when it is enabled, pending, not active, its group is enabled, and its priority is numerically below the mask.
- R4: Among qualifying lines, the lowest priority value wins. On equal priority the lower line number wins.
- R5: The acknowledge word carries the line number in bits [9:0]. For lines 0 to 15 it also carries that line's 3-bit source CPU in bits [12:10]; for other lines those bits are 0. All other bits are 0.
- R6: An acknowledge read that has a winner raises `pend_clr` for that line only, in the cycle of the read. The line then becomes active and is not presented again until it is completed.
- R7: When nothing qualifies, an acknowledge read returns 1023, raises no `pend_clr` bit and changes no state.
- R8: Writing to end-of-interrupt clears the active state of the line numbered by write-data bits [9:0]. A number of `NUM_LINES` or more (for example 100 or 1023) has no effect.
- R9: A winner in group 1 drives `irq`. A winner in group 0 drives `fiq` when control bit 3 is set, and `irq` otherwise. Both outputs are registered and are never high together.
- R10: Both outputs are low in the cycle after the clock edge that takes an acknowledge read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_enable | input | NUM_LINES | Per-line enable from distributor |
| line_pending | input | NUM_LINES | Per-line pending from distributor |
| line_group | input | NUM_LINES | Per-line group (0 or 1) |
| line_prio | input | NUM_LINES*8 | Per-line 8-bit priority, line i at [8i+7:8i] |
| sgi_src | input | NUM_SGI*3 | Source CPU of each software line, line i at [3i+2:3i] |
| pend_clr | output | NUM_LINES | One-cycle clear-pending strobe to distributor |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
Arbitration is tried with three pending lines that mix a distinct lowest priority and a tie. Acknowledging them one after another shows whether the value comparison and the lower-number tie-break are both honoured. A priority exactly equal to the mask, and then a mask one higher, separate a strict compare from an inclusive one. A disabled group shows that the group gate works, and toggling control bit 3 shows the output steering. To show that active lines are held back, a line is re-pended while it is active. An end-of-interrupt with number 100, whose low six bits alias line 36, exposes truncated decoding. A software line with a nonzero source CPU checks the field packing in the acknowledge word.

// File: rtl/icpu_pkg.sv
package icpu_pkg;

    localparam int PRIO_W  = 8;
    localparam int ID_W    = 10;
    localparam int CPU_W   = 3;
    localparam int CPU_LSB = 10;
    localparam int REG_AW  = 12;

    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;

    localparam logic [REG_AW-1:0] OFF_CTRL = 12'h000;
    localparam logic [REG_AW-1:0] OFF_MASK = 12'h004;
    localparam logic [REG_AW-1:0] OFF_ACK  = 12'h00C;
    localparam logic [REG_AW-1:0] OFF_EOI  = 12'h010;

    // bit positions inside the control word
    localparam int CTL_G0  = 0;
    localparam int CTL_G1  = 1;
    localparam int CTL_FIQ = 3;

    typedef struct packed {
        logic              grp0_en;
        logic              grp1_en;
        logic              fiq_en;
        logic [PRIO_W-1:0] mask;
        logic [31:0]       rdata;
        logic              irq;
        logic              fiq;
    } icpu_state_t;

endpackage

// File: rtl/icpu_arbiter.sv
module icpu_arbiter
    import icpu_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]        cand,
    input  logic [NUM_LINES*PRIO_W-1:0] prio,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_idx
);

    logic [PRIO_W-1:0] best_prio;

    // strict less-than keeps the earlier (lower) line on a tie
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && (!win_valid || (prio[i*PRIO_W +: PRIO_W] < best_prio))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/icpu_active.sv
module icpu_active #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic [NUM_LINES-1:0] clr_vec,
    output logic [NUM_LINES-1:0] active
);

    logic [NUM_LINES-1:0] act_d, act_q;

    always_comb begin
        act_d = (act_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/intc_cpu_iface.sv
module intc_cpu_iface
    import icpu_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_SGI   = 16,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        line_enable,
    input  logic [NUM_LINES-1:0]        line_pending,
    input  logic [NUM_LINES-1:0]        line_group,
    input  logic [NUM_LINES*PRIO_W-1:0] line_prio,
    input  logic [NUM_SGI*CPU_W-1:0]    sgi_src,
    output logic [NUM_LINES-1:0]        pend_clr,
    input  logic                        reg_en,
    input  logic                        reg_wr,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic                        irq,
    output logic                        fiq
);

    icpu_state_t st_d, st_q;

    logic [NUM_LINES-1:0] cand;
    logic [NUM_LINES-1:0] active_vec;
    logic [NUM_LINES-1:0] eoi_clr;
    logic                 win_valid;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_group;
    logic                 ack_rd;
    logic                 eoi_wr;
    logic [31:0]          ack_word;
    logic                 unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:ID_W], reg_wdata[2]};

    assign ack_rd = reg_en & ~reg_wr & (reg_addr == OFF_ACK);
    assign eoi_wr = reg_en &  reg_wr & (reg_addr == OFF_EOI);

    // per-line qualification, strobes and completion decode
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign cand[g] = line_enable[g] & line_pending[g] & ~active_vec[g]
                       & (line_group[g] ? st_q.grp1_en : st_q.grp0_en)
                       & (line_prio[g*PRIO_W +: PRIO_W] < st_q.mask);
        assign pend_clr[g] = ack_rd & win_valid & (win_idx == IDX_W'(g));
        assign eoi_clr[g]  = eoi_wr & (reg_wdata[ID_W-1:0] == ID_W'(g));
    end

    icpu_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
        .cand      (cand),
        .prio      (line_prio),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    icpu_active #(.NUM_LINES(NUM_LINES)) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (pend_clr),
        .clr_vec (eoi_clr),
        .active  (active_vec)
    );

    assign win_group = line_group[win_idx];

    always_comb begin
        ack_word = '0;
        if (win_valid) begin
            ack_word[ID_W-1:0] = ID_W'(win_idx);
            if (int'(win_idx) < NUM_SGI) begin
                ack_word[CPU_LSB +: CPU_W] = sgi_src[int'(win_idx)*CPU_W +: CPU_W];
            end
        end else begin
            ack_word[ID_W-1:0] = SPURIOUS_ID;
        end
    end

    always_comb begin
        st_d = st_q;
        if (reg_en && reg_wr) begin
            case (reg_addr)
                OFF_CTRL: begin
                    st_d.grp0_en = reg_wdata[CTL_G0];
                    st_d.grp1_en = reg_wdata[CTL_G1];
                    st_d.fiq_en  = reg_wdata[CTL_FIQ];
                end
                OFF_MASK: st_d.mask = reg_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
        if (reg_en && !reg_wr) begin
            case (reg_addr)
                OFF_CTRL: st_d.rdata = {28'd0, st_q.fiq_en, 1'b0, st_q.grp1_en, st_q.grp0_en};
                OFF_MASK: st_d.rdata = {{(32-PRIO_W){1'b0}}, st_q.mask};
                OFF_ACK:  st_d.rdata = ack_word;
                default:  st_d.rdata = '0;
            endcase
        end
        // the acknowledged line is leaving; hold both outputs low for a cycle
        if (ack_rd || !win_valid) begin
            st_d.irq = 1'b0;
            st_d.fiq = 1'b0;
        end else begin
            st_d.fiq = ~win_group & st_q.fiq_en;
            st_d.irq = ~(~win_group & st_q.fiq_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign irq       = st_q.irq;
    assign fiq       = st_q.fiq;

endmodule

// File: rtl/icpu_ack_chk.sv
module icpu_ack_chk
    import icpu_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_en,
    input logic                 reg_wr,
    input logic [REG_AW-1:0]    reg_addr,
    input logic [31:0]          reg_rdata,
    input logic [NUM_LINES-1:0] pend_clr,
    input logic [NUM_LINES-1:0] active_q,
    input logic                 irq,
    input logic                 fiq
);

    logic ack_rd;
    assign ack_rd = reg_en && !reg_wr && (reg_addr == OFF_ACK);

    p_single_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && fiq));

    p_clr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr));

    p_clr_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr != '0) |-> ack_rd);

    p_clr_not_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr & active_q) == '0);

    p_becomes_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr != '0) |=> ((active_q & $past(pend_clr)) == $past(pend_clr)));

    p_drop_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> (!irq && !fiq));

    p_spurious_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && pend_clr == '0) |=> (reg_rdata == 32'd1023));

    p_spurious_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && pend_clr == '0) |=> $stable(active_q));

endmodule

bind intc_cpu_iface icpu_ack_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pend_clr  (pend_clr),
    .active_q  (active_vec),
    .irq       (irq),
    .fiq       (fiq)
);

// File: tb/tb_intc_cpu_iface.sv
`timescale 1ns/1ps
module tb_intc_cpu_iface;

    localparam int N = 64;
    localparam int S = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  en = '0, grp = '0, dpend, set_req = '0, clr_req = '0;
    logic [N*8-1:0] prio = '0;
    logic [S*3-1:0] sgi = '0;
    logic [N-1:0]  pend_clr;
    logic          reg_en = 1'b0, reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq, fiq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intc_cpu_iface #(.NUM_LINES(N), .NUM_SGI(S)) dut (
        .clk(clk), .rst_n(rst_n), .line_enable(en), .line_pending(dpend),
        .line_group(grp), .line_prio(prio), .sgi_src(sgi), .pend_clr(pend_clr),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .fiq(fiq)
    );

    // distributor model: pending set by the bench, cleared by the strobe
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) dpend <= '0;
        else        dpend <= (dpend | set_req) & ~pend_clr & ~clr_req;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [N-1:0] clr);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 clr = pend_clr;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic line(input int i, input bit g, input logic [7:0] p);
        @(negedge clk);
        en[i] = 1'b1; grp[i] = g; prio[i*8 +: 8] = p;
    endtask

    task automatic raise(input int i);
        @(negedge clk); set_req[i] = 1'b1;
        @(negedge clk); set_req = '0;
    endtask

    task automatic outs(input bit ei, input bit ef, input string req);
        idle(3);
        check(irq === ei && fiq === ef, req, {30'd0, fiq, irq}, {30'd0, ef, ei});
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [N-1:0] c;
        check(irq === 1'b0 && fiq === 1'b0, "R1 outputs", {30'd0, fiq, irq}, 0);
        rd(12'h000, d, c); check(d === 0, "R1 ctrl", d, 0);
        rd(12'h004, d, c); check(d === 0, "R1 mask", d, 0);
        rd(12'h00C, d, c); check(d === 32'd1023, "R1 ack", d, 1023);
    endtask

    task automatic t_regs();
        logic [31:0] d; logic [N-1:0] c;
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, d, c); check(d === 32'hB, "R2 ctrl bits", d, 32'hB);
        wr(12'h004, 32'h0000_01FF);
        rd(12'h004, d, c); check(d === 32'hFF, "R2 mask width", d, 32'hFF);
        wr(12'h000, 32'h3);
        wr(12'h004, 32'h80);
    endtask

    task automatic t_basic();
        logic [31:0] d; logic [N-1:0] c;
        line(40, 1'b1, 8'h10); raise(40);
        outs(1'b1, 1'b0, "R9 group1 irq");
        rd(12'h00C, d, c);
        check(d === 32'd40, "R5 ack id", d, 40);
        check(c === (64'd1 << 40), "R6 strobe", c[31:0], 0);
        check(irq === 1'b0, "R10 drop", {31'd0, irq}, 0);
        raise(40);
        outs(1'b0, 1'b0, "R6 active held back");
        wr(12'h010, 32'd40);
        outs(1'b1, 1'b0, "R8 eoi releases");
        rd(12'h00C, d, c); check(d === 32'd40, "R8 re-ack", d, 40);
        wr(12'h010, 32'd40);
        en[40] = 1'b0;
    endtask

    task automatic t_mask();
        logic [31:0] d; logic [N-1:0] c;
        line(50, 1'b1, 8'h80); raise(50);
        outs(1'b0, 1'b0, "R3 prio equal to mask");
        wr(12'h004, 32'h81);
        outs(1'b1, 1'b0, "R3 prio below mask");
        rd(12'h00C, d, c); check(d === 32'd50, "R3 ack", d, 50);
        wr(12'h010, 32'd50);
        wr(12'h004, 32'h80);
        en[50] = 1'b0;
        @(negedge clk); en[51] = 1'b0; prio[51*8 +: 8] = 8'h00; grp[51] = 1'b1;
        raise(51);
        outs(1'b0, 1'b0, "R3 disabled line");
        rd(12'h00C, d, c);
        check(d === 32'd1023 && c === '0, "R7 spurious", d, 1023);
        idle(1);
        check(dpend[51] === 1'b1, "R7 pending kept", {31'd0, dpend[51]}, 1);
        clr_req[51] = 1'b1; idle(1); clr_req = '0;
    endtask

    task automatic t_arb();
        logic [31:0] d; logic [N-1:0] c;
        line(20, 1'b1, 8'h30); line(25, 1'b1, 8'h20); line(30, 1'b1, 8'h20);
        raise(20); raise(25); raise(30);
        idle(2);
        rd(12'h00C, d, c); check(d === 32'd25, "R4 lowest value, tie low id", d, 25);
        rd(12'h00C, d, c); check(d === 32'd30, "R4 second", d, 30);
        rd(12'h00C, d, c); check(d === 32'd20, "R4 third", d, 20);
        rd(12'h00C, d, c); check(d === 32'd1023, "R7 none left", d, 1023);
        wr(12'h010, 32'd25); wr(12'h010, 32'd30); wr(12'h010, 32'd20);
        en[20] = 1'b0; en[25] = 1'b0; en[30] = 1'b0;
    endtask

    task automatic t_group();
        logic [31:0] d; logic [N-1:0] c;
        wr(12'h000, 32'h2);
        line(33, 1'b0, 8'h10); raise(33);
        outs(1'b0, 1'b0, "R3 group0 disabled");
        wr(12'h000, 32'h3);
        outs(1'b1, 1'b0, "R9 group0 on irq");
        wr(12'h000, 32'hB);
        outs(1'b0, 1'b1, "R9 group0 on fiq");
        rd(12'h00C, d, c); check(d === 32'd33, "R9 ack", d, 33);
        check(fiq === 1'b0, "R10 fiq drop", {31'd0, fiq}, 0);
        wr(12'h010, 32'd33);
        wr(12'h000, 32'h3);
        en[33] = 1'b0;
    endtask

    task automatic t_sgi();
        logic [31:0] d; logic [N-1:0] c;
        @(negedge clk); sgi[9*3 +: 3] = 3'd5; sgi[7*3 +: 3] = 3'd7;
        line(9, 1'b1, 8'h05); line(17, 1'b1, 8'h06);
        raise(9); raise(17);
        idle(2);
        rd(12'h00C, d, c); check(d === 32'h1409, "R5 source cpu", d, 32'h1409);
        check(irq === 1'b0, "R10 drop with next", {31'd0, irq}, 0);
        idle(1);
        check(irq === 1'b1, "R9 next presented", {31'd0, irq}, 1);
        rd(12'h00C, d, c); check(d === 32'd17, "R5 no cpu field", d, 17);
        wr(12'h010, 32'h1409); wr(12'h010, 32'd17);
        en[9] = 1'b0; en[17] = 1'b0;
    endtask

    task automatic t_eoi_range();
        logic [31:0] d; logic [N-1:0] c;
        line(36, 1'b1, 8'h10); raise(36);
        idle(2);
        rd(12'h00C, d, c); check(d === 32'd36, "R8 ack", d, 36);
        raise(36);
        wr(12'h010, 32'd100);
        outs(1'b0, 1'b0, "R8 id 100 ignored");
        wr(12'h010, 32'd1023);
        outs(1'b0, 1'b0, "R8 id 1023 ignored");
        wr(12'h010, 32'd36);
        outs(1'b1, 1'b0, "R8 own id releases");
        rd(12'h00C, d, c); wr(12'h010, 32'd36);
        en[36] = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_regs();
        t_basic();
        t_mask();
        t_arb();
        t_group();
        t_sgi();
        t_eoi_range();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule